// File: doc/BRIEF.md
# Two-Bank Interleaved Low-Power Memory

This block is a memory wrapper that saves power. The host sees a single word-addressed memory. Inside, the block builds that memory from two half-size synchronous banks. The lowest address bit picks the bank, so neighbouring addresses fall in different banks. Only the addressed bank is enabled in any cycle. The other bank does no internal access, and its read port and write port stay quiet.

Reads are synchronous, with one cycle of latency. The bank-select bit is captured in a register on the same edge that launches the read. The registered bit then steers the output multiplexer, so the select lines up with the data that comes back. The full configuration has a 15-bit address (two banks of 16K words) and a 32-bit data path. The default parameters use an 11-bit address so that elaboration stays small. A host uses the block like any single-port RAM, with one read or one write request per cycle. Both may also be asserted in the same cycle for the same address.

Top module: `twin_bank_mem`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits (ADDR_W=15 and DATA_W=32 in the full configuration). A read of any address returns the data most recently written to that address.
- R2: Address bit 0 selects the bank: 0 selects the even bank and 1 selects the odd bank. Address bits ADDR_W-1 down to 1 form the word index inside the bank, so addresses 2k and 2k+1 hold independent words.
- R3: In any cycle, at most one bank has its active-low output enable asserted or its write input asserted. The bank that is not addressed gets neither.
- R4: When neither a read nor a write is requested, both banks stay disabled and the stored contents do not change.
- R5: Read data for a read requested at a clock edge appears on rdata after that edge and is valid until the next edge.
- R6: The output select is a registered copy of address bit 0, loaded only on a read request. While no read is requested, the select and rdata hold their values, even when the address changes.
- R7: A write to an even address followed by a read of the next odd address returns the odd word. A later read of the even address returns the new even word.
- R8: When a read and a write to the same address are requested in one cycle, the read returns the previous content and the write takes effect.
- R9: After reset, rdata is all zeros and the select points at the even bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address; bit 0 selects the bank |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rdata | output | DATA_W | Read data, one cycle after the request |

## Verification
The assertions assume that addr, wdata, wr_en and rd_en are known and settled at each rising edge while reset is released. They also assume that a location is written before it is read, because the arrays are not cleared. The bench changes inputs only on the falling clock edge. It writes every address once before any read, so each read hits defined data that a full-size reference array also holds. It changes the address on idle cycles to show that the select register and the output hold their values.

// File: rtl/twin_bank_pkg.sv
package twin_bank_pkg;

  // Bank index: the low address bits.
  function automatic int unsigned bank_of(input logic [31:0] a, input int unsigned bits);
    return int'(a & ((32'd1 << bits) - 32'd1));
  endfunction

  // Word index inside a bank: the address with the bank bits removed.
  function automatic int unsigned word_of(input logic [31:0] a, input int unsigned bits);
    return int'(a >> bits);
  endfunction

endpackage

// File: rtl/tb_sel_reg.sv
module tb_sel_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d)); // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R6
endmodule

// File: rtl/tb_bank_decode.sv
module tb_bank_decode #(
  parameter int NB = 2,
  parameter int BB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [BB-1:0] bank_sel,
  output logic [NB-1:0] oe_n,
  output logic [NB-1:0] we
);
  logic [NB-1:0] bank_busy;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    logic hit;
    assign hit          = (bank_sel == BB'(b));
    assign oe_n[b]      = !(rd_en && hit);
    assign we[b]        = wr_en && hit;
    assign bank_busy[b] = !oe_n[b] || we[b];
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_busy)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> bank_busy == '0); // R4
endmodule

// File: rtl/tb_mem_bank.sv
module tb_mem_bank #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe_n,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= d;
  end

  // The old word is read because the write uses a nonblocking update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!oe_n) q <= mem[a];
  end

  AST_BANK_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> $stable(q)); // R6
endmodule

// File: rtl/twin_bank_mem.sv
module twin_bank_mem
  import twin_bank_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 32,
  parameter int BANK_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);
  localparam int NB  = 1 << BANK_BITS;
  localparam int WAW = ADDR_W - BANK_BITS;

  logic [BANK_BITS-1:0] bank_sel;
  logic [BANK_BITS-1:0] sel_q;
  logic [WAW-1:0]       word_idx;
  logic [NB-1:0]        oe_n;
  logic [NB-1:0]        we;
  logic [DATA_W-1:0]    bank_q [NB];

  assign bank_sel = BANK_BITS'(bank_of(32'(addr), BANK_BITS));
  assign word_idx = WAW'(word_of(32'(addr), BANK_BITS));

  tb_bank_decode #(.NB(NB), .BB(BANK_BITS)) i_dec (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .bank_sel(bank_sel), .oe_n(oe_n), .we(we)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    tb_mem_bank #(.AW(WAW), .DW(DATA_W)) i_bank (
      .clk(clk), .rst_n(rst_n), .oe_n(oe_n[b]), .we(we[b]),
      .a(word_idx), .d(wdata), .q(bank_q[b])
    );
  end

  tb_sel_reg #(.W(BANK_BITS)) i_sel (
    .clk(clk), .rst_n(rst_n), .load(rd_en), .d(bank_sel), .q(sel_q)
  );

  assign rdata = bank_q[sel_q];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R6
  AST_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rdata == bank_q[$past(bank_sel)]); // R5
endmodule

// File: tb/test_twin_bank_mem.sv
module test_twin_bank_mem;
  localparam int AW    = 11;
  localparam int DW    = 32;
  localparam int DEPTH = 1 << AW;
  localparam int NV    = 14;

  // Vector fields: {write, read, address[15:0], data[31:0]}
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd5,    32'h1111_1111},
    {1'b0, 1'b1, 16'd5,    32'h0},
    {1'b1, 1'b0, 16'd4,    32'h2222_2222},
    {1'b0, 1'b1, 16'd5,    32'h0},
    {1'b0, 1'b1, 16'd4,    32'h0},
    {1'b1, 1'b1, 16'd4,    32'h3333_3333},
    {1'b0, 1'b1, 16'd4,    32'h0},
    {1'b0, 1'b1, 16'd2047, 32'h0},
    {1'b1, 1'b0, 16'd2047, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 16'd2047, 32'h0},
    {1'b0, 1'b1, 16'd2046, 32'h0},
    {1'b1, 1'b0, 16'd1,    32'h0},
    {1'b0, 1'b1, 16'd1,    32'h0},
    {1'b0, 1'b1, 16'd0,    32'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rdata;

  logic [DW-1:0] ref_mem [DEPTH];
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  twin_bank_mem #(.ADDR_W(AW), .DATA_W(DW)) i_twin_bank_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  function automatic logic [DW-1:0] fill(input int a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0001_0203);
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request, then one idle cycle. Read data is checked after the edge.
  task automatic op(input logic w, input logic r, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    addr = a; wdata = d; wr_en = w; rd_en = r;
    exp = ref_mem[a];
    if (w) ref_mem[a] = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (r) check(rdata, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check(rdata, '0, "R9 reset rdata");
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata, '0, "R9 idle after reset");

    // R1: fill the whole space
    for (int a = 0; a < DEPTH; a++) op(1'b1, 1'b0, AW'(a), fill(a), "R1 fill");

    for (int i = 0; i < NV; i++)
      op(VEC[i][49], VEC[i][48], AW'(VEC[i][47:32]), VEC[i][31:0], "R1 table");

    // R2: neighbours hold independent words
    op(1'b0, 1'b1, AW'(10), 32'h0, "R2 even word");
    op(1'b0, 1'b1, AW'(11), 32'h0, "R2 odd word");
    op(1'b0, 1'b1, AW'(12), 32'h0, "R2 next even word");

    // R7: even write, odd read, even read
    op(1'b1, 1'b0, AW'(20), 32'hCAFE_0020, "R7 write even");
    op(1'b0, 1'b1, AW'(21), 32'h0, "R7 read odd");
    op(1'b0, 1'b1, AW'(20), 32'h0, "R7 read even");
    op(1'b1, 1'b0, AW'(31), 32'hBEEF_0031, "R3 write odd");
    op(1'b0, 1'b1, AW'(30), 32'h0, "R3 even untouched");

    // R8: read and write together
    op(1'b1, 1'b1, AW'(40), 32'h4040_4040, "R8 old data");
    op(1'b0, 1'b1, AW'(40), 32'h0, "R8 new data");

    // R6 and R4: output holds while idle and the address moves
    op(1'b0, 1'b1, AW'(21), 32'h0, "R6 load select");
    held = rdata;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      addr = AW'(k * 7);
      check(rdata, held, "R6 hold while idle");
    end
    op(1'b0, 1'b1, AW'(0), 32'h0, "R4 contents kept 0");
    op(1'b0, 1'b1, AW'(35), 32'h0, "R4 contents kept 35");

    // R5: back-to-back reads, each valid after its own edge
    @(negedge clk);
    addr = AW'(50); rd_en = 1'b1;
    @(negedge clk);
    check(rdata, ref_mem[50], "R5 first read");
    addr = AW'(51);
    @(negedge clk);
    check(rdata, ref_mem[51], "R5 second read");
    rd_en = 1'b0;

    // R9: reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(rdata, '0, "R9 second reset");
    rst_n = 1'b1;
    op(1'b0, 1'b1, AW'(7), 32'h0, "R9 contents after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule